// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core (RV32I Subset)

This block is a small in-order processor core that runs a subset of the 32-bit RISC-V base integer instructions: ADDI, ADD, SUB, AND, OR, XOR, SLT, LW, SW and BEQ. It has five stages (fetch, decode, execute, memory, write-back). The stages are separated by four pipeline registers: fetch/decode, decode/execute, execute/memory and memory/write-back. The core holds two word-addressed arrays of its own, one for instructions and one for data, so a fetch and a load or store never compete for a port. Outside reset there is no bus. A loader port writes either array, and two debug read ports show one register and one data word.

Hazards are handled in the pipeline. Execute takes its operands from the execute/memory or memory/write-back registers when a newer value is in flight there. A load followed at once by a consumer holds fetch and decode for one cycle and sends a bubble into execute. Branches are predicted not taken and are resolved in execute. A taken BEQ redirects the PC and empties the two younger stages. Each cycle a hazard controller picks one of three pipeline control states:
- `CTL_RUN`: every stage advances.
- `CTL_STALL`: the PC and the fetch/decode register hold, and execute receives a bubble.
- `CTL_REDIRECT`: the PC loads the branch target, and the fetch/decode and decode/execute registers are cleared.

The controller leaves `CTL_RUN` for `CTL_STALL` on a load-use match and for `CTL_REDIRECT` on a taken branch. If both conditions hold in the same cycle, `CTL_REDIRECT` wins. Every state returns to `CTL_RUN` in the next cycle unless its condition still holds.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high the PC becomes 0, all 32 registers read 0, and no register or data word is written by the pipeline.
- R2: Register x0 always reads 0. An instruction with rd = 0 changes nothing.
- R3: Each operation produces the RV32I result. ADD, SUB, AND, OR and XOR work on 32 bits. SLT gives 1 or 0 from a signed compare. ADDI adds the sign-extended immediate in bits 31:20.
- R4: An instruction that reads a register written by one of the two instructions just before it gets the new value. The value comes from the execute/memory or the memory/write-back register, and the newer of the two takes priority.
- R5: When an LW is directly followed by an instruction whose rs1 or rs2 field equals the load's nonzero rd, the core inserts exactly one bubble. The consumer then sees the loaded value. While the stall lasts, the PC holds.
- R6: SW writes rs2 to data word (rs1 + S-immediate)[9:2], where the S-immediate is {bits 31:25, bits 11:7} sign-extended. LW reads that word. The store data is forwarded like any other operand.
- R7: A taken BEQ sets the PC to its own address plus the B-immediate {bit 31, bit 7, bits 30:25, bits 11:8, 0}, sign-extended. The two instructions fetched after the branch leave no effect.
- R8: A BEQ whose operands differ falls through, and fetch continues at PC + 4.
- R9: A register written back in the same cycle that a younger instruction decodes it is passed to that reader directly from the write port.
- R10: An encoding outside the supported set (for example opcode 0110011 with funct3 = 001) behaves as a no-op.
- R11: With `ld_en` high, `ld_data` is written to word `ld_addr` of the instruction array (`ld_dmem` = 0) or the data array (`ld_dmem` = 1) on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Loader write strobe |
| ld_dmem | input | 1 | Loader target: 0 instruction array, 1 data array |
| ld_addr | input | LD_AW | Loader word address |
| ld_data | input | 32 | Loader write word |
| dbg_reg_addr | input | 5 | Debug register index |
| dbg_reg_data | output | 32 | Debug register value (x0 reads 0) |
| dbg_mem_addr | input | DMEM_AW | Debug data word index |
| dbg_mem_data | output | 32 | Debug data word value |

## Verification
The assertions take for granted that `rst` is high at the first clock edge. They also assume the loader is used only while `rst` is high, so the instruction array never changes under a running pipeline. They further assume that the program contains only the listed instructions or harmless unsupported words. The bench loads both arrays during reset and releases reset only after loading is done. Its constrained random section uses data addresses only inside the data array and draws destination registers from a fixed range, so the directed results stay intact for their checks.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    typedef enum logic [1:0] {
        CTL_RUN      = 2'd0,
        CTL_STALL    = 2'd1,
        CTL_REDIRECT = 2'd2
    } pipe_ctl_e;

    // ALU select is {funct7[5], funct3} for register-register operations
    typedef enum logic [3:0] {
        ALU_ADD = 4'b0000,
        ALU_SLT = 4'b0010,
        ALU_XOR = 4'b0100,
        ALU_OR  = 4'b0110,
        ALU_AND = 4'b0111,
        ALU_SUB = 4'b1000
    } alu_op_e;

    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_MEM = 2'd1,
        FWD_WB  = 2'd2
    } fwd_e;

    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;

    typedef struct packed {
        logic    regwrite;
        logic    memread;
        logic    memwrite;
        logic    memtoreg;
        logic    alusrc;
        logic    branch;
        alu_op_e aluop;
    } ctl_t;

    // Operand source choice: the newer in-flight result wins (R4)
    function automatic fwd_e fwd_pick(
        input logic [4:0] rs,
        input logic [4:0] mem_rd,
        input logic       mem_wr,
        input logic       mem_ld,
        input logic [4:0] wb_rd,
        input logic       wb_wr
    );
        if (mem_wr && !mem_ld && (mem_rd != 5'd0) && (mem_rd == rs))
            return FWD_MEM;
        else if (wb_wr && (wb_rd != 5'd0) && (wb_rd == rs))
            return FWD_WB;
        return FWD_RF;
    endfunction

endpackage

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
    parameter int NREG = 32,
    parameter int XW   = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [AW-1:0]       wa,
    input  logic [XW-1:0]       wd,
    input  logic [1:0][AW-1:0]  ra,
    output logic [1:0][XW-1:0]  rdat,
    input  logic [AW-1:0]       dra,
    output logic [XW-1:0]       ddat
);
    logic [XW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Decode read ports see a same-cycle write-back (R9)
    for (genvar g = 0; g < 2; g++) begin : g_rd
        always_comb begin
            if (ra[g] == '0)
                rdat[g] = '0;
            else if (we && (wa == ra[g]))
                rdat[g] = wd;
            else
                rdat[g] = regs[ra[g]];
        end
    end

    assign ddat = (dra == '0) ? '0 : regs[dra];

endmodule

// File: rtl/pipe5_decode.sv
module pipe5_decode
    import pipe5_pkg::*;
(
    input  logic [31:0] instr,
    output ctl_t        ctl,
    output logic [31:0] imm,
    output logic [4:0]  rs1,
    output logic [4:0]  rs2,
    output logic [4:0]  rd
);
    logic [2:0]  f3;
    logic [6:0]  f7;
    logic [31:0] imm_i, imm_s, imm_b;
    logic        r_ok;

    assign rd  = instr[11:7];
    assign f3  = instr[14:12];
    assign rs1 = instr[19:15];
    assign rs2 = instr[24:20];
    assign f7  = instr[31:25];

    assign imm_i = {{20{instr[31]}}, instr[31:20]};
    assign imm_s = {{20{instr[31]}}, instr[31:25], instr[11:7]};
    assign imm_b = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};

    assign r_ok = ((f7 == 7'h00) && ((f3 == 3'd0) || (f3 == 3'd2) || (f3 == 3'd4) ||
                                     (f3 == 3'd6) || (f3 == 3'd7)))
               || ((f7 == 7'h20) && (f3 == 3'd0));

    always_comb begin
        ctl = '0;
        imm = '0;
        case (instr[6:0])
            OPC_OPIMM: if (f3 == 3'd0) begin
                ctl.regwrite = 1'b1;
                ctl.alusrc   = 1'b1;
                ctl.aluop    = ALU_ADD;
                imm          = imm_i;
            end
            OPC_OP: if (r_ok) begin
                ctl.regwrite = 1'b1;
                ctl.aluop    = alu_op_e'({instr[30], f3});
            end
            OPC_LOAD: if (f3 == 3'd2) begin
                ctl.regwrite = 1'b1;
                ctl.memread  = 1'b1;
                ctl.memtoreg = 1'b1;
                ctl.alusrc   = 1'b1;
                ctl.aluop    = ALU_ADD;
                imm          = imm_i;
            end
            OPC_STORE: if (f3 == 3'd2) begin
                ctl.memwrite = 1'b1;
                ctl.alusrc   = 1'b1;
                ctl.aluop    = ALU_ADD;
                imm          = imm_s;
            end
            OPC_BRANCH: if (f3 == 3'd0) begin
                ctl.branch = 1'b1;
                ctl.aluop  = ALU_SUB;
                imm        = imm_b;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
    import pipe5_pkg::*;
#(
    parameter int XW = 32
) (
    input  logic [XW-1:0] a,
    input  logic [XW-1:0] b,
    input  alu_op_e       op,
    output logic [XW-1:0] y
);
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? XW'(1) : '0;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/pipe5_hazard.sv
module pipe5_hazard
    import pipe5_pkg::*;
(
    input  logic [4:0] id_rs1,
    input  logic [4:0] id_rs2,
    input  logic [4:0] ex_rd,
    input  logic       ex_memread,
    input  logic       ex_taken,
    output pipe_ctl_e  ctl
);
    logic load_use;

    assign load_use = ex_memread && (ex_rd != 5'd0) &&
                      ((ex_rd == id_rs1) || (ex_rd == id_rs2));

    // Redirect outranks stall: the stalled reader is squashed anyway
    always_comb begin
        if (ex_taken)
            ctl = CTL_REDIRECT;
        else if (load_use)
            ctl = CTL_STALL;
        else
            ctl = CTL_RUN;
    end

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int IMEM_AW = 10,
    parameter int DMEM_AW = 8,
    localparam int LD_AW  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_en,
    input  logic               ld_dmem,
    input  logic [LD_AW-1:0]   ld_addr,
    input  logic [31:0]        ld_data,
    input  logic [4:0]         dbg_reg_addr,
    output logic [31:0]        dbg_reg_data,
    input  logic [DMEM_AW-1:0] dbg_mem_addr,
    output logic [31:0]        dbg_mem_data
);
    localparam int IMEM_DEPTH = 1 << IMEM_AW;
    localparam int DMEM_DEPTH = 1 << DMEM_AW;

    logic [31:0] imem [IMEM_DEPTH];
    logic [31:0] dmem [DMEM_DEPTH];

    pipe_ctl_e   hz_ctl;

    // ---------------- fetch
    logic [31:0] pc_q, if_instr;
    // ---------------- decode
    logic [31:0] id_pc, id_instr, id_imm;
    logic [4:0]  id_rs1, id_rs2, id_rd;
    ctl_t        id_ctl;
    logic [1:0][4:0]  rf_ra;
    logic [1:0][31:0] rf_rd;
    // ---------------- execute
    ctl_t        ex_ctl;
    logic [31:0] ex_pc, ex_a, ex_b, ex_imm;
    logic [4:0]  ex_rs1, ex_rs2, ex_rd;
    logic [31:0] ex_opa, ex_opb, ex_alu_b, ex_y, ex_target;
    fwd_e        fa, fb;
    logic        ex_taken;
    // ---------------- memory
    logic        mem_regwrite, mem_memtoreg, mem_memwrite;
    logic [31:0] mem_alu, mem_wdata, mem_rdata;
    logic [4:0]  mem_rd;
    // ---------------- write-back
    logic        wb_regwrite, wb_memtoreg;
    logic [31:0] wb_alu, wb_load, wb_val;
    logic [4:0]  wb_rd;

    // Loader port (R11)
    always_ff @(posedge clk) begin
        if (ld_en && !ld_dmem) imem[ld_addr[IMEM_AW-1:0]] <= ld_data;
    end

    // ================= IF
    assign if_instr = imem[pc_q[IMEM_AW+1:2]];

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            unique case (hz_ctl)
                CTL_RUN:      pc_q <= pc_q + 32'd4;
                CTL_STALL:    pc_q <= pc_q;
                CTL_REDIRECT: pc_q <= ex_target;
                default:      pc_q <= pc_q;
            endcase
        end
    end

    // IF/ID: hold on stall, clear on redirect
    always_ff @(posedge clk) begin
        if (rst || (hz_ctl == CTL_REDIRECT)) begin
            id_pc    <= '0;
            id_instr <= '0;
        end else if (hz_ctl != CTL_STALL) begin
            id_pc    <= pc_q;
            id_instr <= if_instr;
        end
    end

    // ================= ID
    pipe5_decode u_dec (
        .instr (id_instr),
        .ctl   (id_ctl),
        .imm   (id_imm),
        .rs1   (id_rs1),
        .rs2   (id_rs2),
        .rd    (id_rd)
    );

    assign rf_ra[0] = id_rs1;
    assign rf_ra[1] = id_rs2;

    pipe5_regfile #(.NREG(32), .XW(32)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .we   (wb_regwrite),
        .wa   (wb_rd),
        .wd   (wb_val),
        .ra   (rf_ra),
        .rdat (rf_rd),
        .dra  (dbg_reg_addr),
        .ddat (dbg_reg_data)
    );

    pipe5_hazard u_hz (
        .id_rs1     (id_rs1),
        .id_rs2     (id_rs2),
        .ex_rd      (ex_rd),
        .ex_memread (ex_ctl.memread),
        .ex_taken   (ex_taken),
        .ctl        (hz_ctl)
    );

    // ID/EX: bubble on stall or redirect
    always_ff @(posedge clk) begin
        if (rst || (hz_ctl != CTL_RUN))
            ex_ctl <= '0;
        else
            ex_ctl <= id_ctl;
        ex_pc  <= id_pc;
        ex_a   <= rf_rd[0];
        ex_b   <= rf_rd[1];
        ex_imm <= id_imm;
        ex_rs1 <= id_rs1;
        ex_rs2 <= id_rs2;
        ex_rd  <= id_rd;
    end

    // ================= EX
    assign fa = fwd_pick(ex_rs1, mem_rd, mem_regwrite, mem_memtoreg, wb_rd, wb_regwrite);
    assign fb = fwd_pick(ex_rs2, mem_rd, mem_regwrite, mem_memtoreg, wb_rd, wb_regwrite);

    always_comb begin
        unique case (fa)
            FWD_MEM: ex_opa = mem_alu;
            FWD_WB:  ex_opa = wb_val;
            default: ex_opa = ex_a;
        endcase
        unique case (fb)
            FWD_MEM: ex_opb = mem_alu;
            FWD_WB:  ex_opb = wb_val;
            default: ex_opb = ex_b;
        endcase
    end

    assign ex_alu_b  = ex_ctl.alusrc ? ex_imm : ex_opb;
    assign ex_target = ex_pc + ex_imm;

    pipe5_alu #(.XW(32)) u_alu (
        .a  (ex_opa),
        .b  (ex_alu_b),
        .op (ex_ctl.aluop),
        .y  (ex_y)
    );

    assign ex_taken = ex_ctl.branch && (ex_y == '0);

    // EX/MEM
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_regwrite <= 1'b0;
            mem_memtoreg <= 1'b0;
            mem_memwrite <= 1'b0;
        end else begin
            mem_regwrite <= ex_ctl.regwrite;
            mem_memtoreg <= ex_ctl.memtoreg;
            mem_memwrite <= ex_ctl.memwrite;
        end
        mem_alu   <= ex_y;
        mem_wdata <= ex_opb;
        mem_rd    <= ex_rd;
    end

    // ================= MEM
    assign mem_rdata    = dmem[mem_alu[DMEM_AW+1:2]];
    assign dbg_mem_data = dmem[dbg_mem_addr];

    always_ff @(posedge clk) begin
        if (ld_en && ld_dmem)
            dmem[ld_addr[DMEM_AW-1:0]] <= ld_data;
        else if (mem_memwrite)
            dmem[mem_alu[DMEM_AW+1:2]] <= mem_wdata;
    end

    // MEM/WB
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_regwrite <= 1'b0;
            wb_memtoreg <= 1'b0;
        end else begin
            wb_regwrite <= mem_regwrite;
            wb_memtoreg <= mem_memtoreg;
        end
        wb_alu  <= mem_alu;
        wb_load <= mem_rdata;
        wb_rd   <= mem_rd;
    end

    // ================= WB
    assign wb_val = wb_memtoreg ? wb_load : wb_alu;

endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk
    import pipe5_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input pipe_ctl_e   hz_ctl,
    input logic [31:0] pc_q,
    input logic [31:0] id_instr,
    input ctl_t        ex_ctl,
    input logic [4:0]  dbg_reg_addr,
    input logic [31:0] dbg_reg_data
);
    p_reset_pc_r1: assert property (@(posedge clk)
        rst |=> (pc_q == 32'd0));

    p_x0_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (dbg_reg_addr == 5'd0) |-> (dbg_reg_data == 32'd0));

    p_stall_holds_pc_r5: assert property (@(posedge clk) disable iff (rst)
        (hz_ctl == CTL_STALL) |=> $stable(pc_q));

    p_stall_bubble_r5: assert property (@(posedge clk) disable iff (rst)
        (hz_ctl == CTL_STALL) |=> (ex_ctl == '0));

    p_redirect_squash_r7: assert property (@(posedge clk) disable iff (rst)
        (hz_ctl == CTL_REDIRECT) |=> ((id_instr == 32'd0) && (ex_ctl == '0)));

    p_seq_fetch_r8: assert property (@(posedge clk) disable iff (rst)
        (hz_ctl == CTL_RUN) |=> (pc_q == $past(pc_q) + 32'd4));

endmodule

bind pipe5_core pipe5_core_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .hz_ctl       (hz_ctl),
    .pc_q         (pc_q),
    .id_instr     (id_instr),
    .ex_ctl       (ex_ctl),
    .dbg_reg_addr (dbg_reg_addr),
    .dbg_reg_data (dbg_reg_data)
);

// File: tb/sim_pipe5_core.sv
`timescale 1ns/1ps
module sim_pipe5_core;
    localparam int IMEM_AW = 10;
    localparam int DMEM_AW = 8;
    localparam int LD_AW   = 10;
    localparam int PLEN    = 63;
    localparam logic [31:0] HALT = 32'h00000063; // beq x0,x0,0

    logic               clk = 1'b0;
    logic               rst;
    logic               ld_en, ld_dmem;
    logic [LD_AW-1:0]   ld_addr;
    logic [31:0]        ld_data;
    logic [4:0]         dbg_reg_addr;
    logic [31:0]        dbg_reg_data;
    logic [DMEM_AW-1:0] dbg_mem_addr;
    logic [31:0]        dbg_mem_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] prog    [128];
    logic [31:0] pre     [16];
    logic [31:0] ref_reg [32];
    logic [31:0] ref_mem [16];

    always #5 clk = ~clk;

    pipe5_core #(.IMEM_AW(IMEM_AW), .DMEM_AW(DMEM_AW)) u0 (
        .clk          (clk),
        .rst          (rst),
        .ld_en        (ld_en),
        .ld_dmem      (ld_dmem),
        .ld_addr      (ld_addr),
        .ld_data      (ld_data),
        .dbg_reg_addr (dbg_reg_addr),
        .dbg_reg_data (dbg_reg_data),
        .dbg_mem_addr (dbg_mem_addr),
        .dbg_mem_data (dbg_mem_data)
    );

    // ---------------- encoders
    function automatic logic [31:0] e_r(input int f7, input int rs2, input int rs1,
                                        input int f3, input int rd);
        logic [6:0] a = f7[6:0];
        logic [4:0] b = rs2[4:0];
        logic [4:0] c = rs1[4:0];
        logic [2:0] d = f3[2:0];
        logic [4:0] e = rd[4:0];
        return {a, b, c, d, e, 7'b0110011};
    endfunction

    function automatic logic [31:0] e_i(input int imm, input int rs1, input int f3,
                                        input int rd, input logic [6:0] op);
        logic [11:0] a = imm[11:0];
        logic [4:0]  c = rs1[4:0];
        logic [2:0]  d = f3[2:0];
        logic [4:0]  e = rd[4:0];
        return {a, c, d, e, op};
    endfunction

    function automatic logic [31:0] e_s(input int imm, input int rs2, input int rs1);
        logic [11:0] a = imm[11:0];
        logic [4:0]  b = rs2[4:0];
        logic [4:0]  c = rs1[4:0];
        return {a[11:5], b, c, 3'b010, a[4:0], 7'b0100011};
    endfunction

    function automatic logic [31:0] e_b(input int imm, input int rs2, input int rs1);
        logic [12:0] a = imm[12:0];
        logic [4:0]  b = rs2[4:0];
        logic [4:0]  c = rs1[4:0];
        return {a[12], a[10:5], b, c, 3'b000, a[4:1], a[11], 7'b1100011};
    endfunction

    // ---------------- sequential reference model of the instruction set
    task automatic iss_run();
        logic [31:0] pc = '0;
        for (int i = 0; i < 32; i++) ref_reg[i] = '0;
        for (int i = 0; i < 16; i++) ref_mem[i] = pre[i];
        for (int step = 0; step < 1000; step++) begin
            logic [31:0] w, a, b, r, im, ad;
            logic [4:0]  rd;
            logic [2:0]  f3;
            logic [6:0]  f7;
            logic        wr;
            w = prog[pc[8:2]];
            if (w == HALT) break;
            rd = w[11:7]; f3 = w[14:12]; f7 = w[31:25];
            a  = ref_reg[w[19:15]]; b = ref_reg[w[24:20]];
            wr = 1'b0; r = '0;
            pc = pc + 32'd4;
            case (w[6:0])
                7'b0010011: if (f3 == 0) begin
                    r = a + {{20{w[31]}}, w[31:20]}; wr = 1'b1;
                end
                7'b0110011: begin
                    wr = 1'b1;
                    if      (f7 == 0 && f3 == 0)    r = a + b;
                    else if (f7 == 7'h20 && f3 == 0) r = a - b;
                    else if (f7 == 0 && f3 == 7)    r = a & b;
                    else if (f7 == 0 && f3 == 6)    r = a | b;
                    else if (f7 == 0 && f3 == 4)    r = a ^ b;
                    else if (f7 == 0 && f3 == 2)    r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    else wr = 1'b0;
                end
                7'b0000011: if (f3 == 2) begin
                    ad = a + {{20{w[31]}}, w[31:20]};
                    r = ref_mem[ad[5:2]]; wr = 1'b1;
                end
                7'b0100011: if (f3 == 2) begin
                    ad = a + {{20{w[31]}}, w[31:25], w[11:7]};
                    ref_mem[ad[5:2]] = b;
                end
                7'b1100011: if (f3 == 0 && a == b) begin
                    im = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
                    pc = pc - 32'd4 + im;
                end
                default: ;
            endcase
            if (wr && rd != 0) ref_reg[rd] = r;
        end
    endtask

    // ---------------- checking helpers
    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic rd_reg(input int idx, output logic [31:0] v);
        @(negedge clk);
        dbg_reg_addr = idx[4:0];
        #1 v = dbg_reg_data;
    endtask

    task automatic rd_mem(input int idx, output logic [31:0] v);
        @(negedge clk);
        dbg_mem_addr = idx[DMEM_AW-1:0];
        #1 v = dbg_mem_data;
    endtask

    task automatic load_word(input bit dsel, input int addr, input logic [31:0] data);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_dmem = dsel;
        ld_addr = addr[LD_AW-1:0];
        ld_data = data;
    endtask

    task automatic build_program();
        int k;
        prog[0]  = e_i(5, 0, 0, 1, 7'b0010011);    // addi x1,x0,5
        prog[1]  = e_i(-3, 0, 0, 2, 7'b0010011);   // addi x2,x0,-3
        prog[2]  = e_r(0, 2, 1, 0, 3);             // add  x3,x1,x2
        prog[3]  = e_r(32, 2, 1, 0, 4);            // sub  x4,x1,x2
        prog[4]  = e_r(0, 2, 1, 7, 5);             // and
        prog[5]  = e_r(0, 2, 1, 6, 6);             // or
        prog[6]  = e_r(0, 2, 1, 4, 7);             // xor
        prog[7]  = e_r(0, 1, 2, 2, 8);             // slt x8,x2,x1
        prog[8]  = e_i(4, 0, 2, 9, 7'b0000011);    // lw x9,4(x0)
        prog[9]  = e_r(0, 1, 9, 0, 10);            // add x10,x9,x1 (load-use)
        prog[10] = e_s(8, 10, 0);                  // sw x10,8(x0)
        prog[11] = e_i(7, 0, 0, 0, 7'b0010011);    // addi x0,x0,7
        prog[12] = e_b(12, 1, 1);                  // beq x1,x1,+12 (taken)
        prog[13] = e_i(99, 0, 0, 11, 7'b0010011);
        prog[14] = e_i(99, 0, 0, 12, 7'b0010011);
        prog[15] = e_b(8, 2, 1);                   // beq x1,x2 (not taken)
        prog[16] = e_i(1, 0, 0, 13, 7'b0010011);
        prog[17] = e_r(0, 2, 1, 2, 14);            // slt x14,x1,x2
        prog[18] = e_r(0, 1, 1, 1, 17);            // unsupported shift
        prog[19] = e_r(0, 13, 13, 0, 16);          // add x16,x13,x13 (wb bypass)
        prog[20] = e_i(-2048, 0, 0, 15, 7'b0010011);
        prog[21] = e_s(12, 15, 0);                 // sw x15,12(x0)
        for (int n = 22; n < PLEN - 1; n++) begin
            int sel = int'($urandom % 9);
            int rd  = 20 + int'($urandom % 12);
            int r1  = 1 + int'($urandom % 31);
            int r2  = 1 + int'($urandom % 31);
            int wa  = 4 * (4 + int'($urandom % 12));
            case (sel)
                0: prog[n] = e_r(0, r2, r1, 0, rd);
                1: prog[n] = e_r(32, r2, r1, 0, rd);
                2: prog[n] = e_r(0, r2, r1, 7, rd);
                3: prog[n] = e_r(0, r2, r1, 6, rd);
                4: prog[n] = e_r(0, r2, r1, 4, rd);
                5: prog[n] = e_r(0, r2, r1, 2, rd);
                6: prog[n] = e_i(int'($urandom % 4096) - 2048, r1, 0, rd, 7'b0010011);
                7: prog[n] = e_i(wa, 0, 2, rd, 7'b0000011);
                default: prog[n] = e_s(wa, r2, 0);
            endcase
        end
        prog[PLEN-1] = HALT;
        for (k = PLEN; k < 128; k++) prog[k] = HALT;
    endtask

    // ---------------- watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- main sequence
    initial begin
        logic [31:0] v;
        rst = 1'b1; ld_en = 1'b0; ld_dmem = 1'b0; ld_addr = '0; ld_data = '0;
        dbg_reg_addr = '0; dbg_mem_addr = '0;
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) pre[i] = $urandom;
        build_program();
        repeat (2) @(posedge clk);
        for (int i = 0; i < PLEN; i++) load_word(1'b0, i, prog[i]);
        for (int i = 0; i < 16; i++)   load_word(1'b1, i, pre[i]);
        @(negedge clk);
        ld_en = 1'b0;

        // R1: registers clear under reset
        rd_reg(1, v);  chk("R1", "x1 in reset", v, 32'd0);
        rd_reg(9, v);  chk("R1", "x9 in reset", v, 32'd0);
        rd_reg(31, v); chk("R1", "x31 in reset", v, 32'd0);
        // R11: loader wrote the data array
        rd_mem(1, v);  chk("R11", "loaded word 1", v, pre[1]);
        rd_mem(15, v); chk("R11", "loaded word 15", v, pre[15]);

        iss_run();

        @(negedge clk);
        rst = 1'b0;
        repeat (400) @(negedge clk);

        rd_reg(3, v);  chk("R4", "x3 add after two producers", v, 32'd2);
        rd_reg(4, v);  chk("R3", "x4 sub", v, 32'd8);
        rd_reg(5, v);  chk("R3", "x5 and", v, 32'd5);
        rd_reg(6, v);  chk("R3", "x6 or", v, 32'hFFFFFFFD);
        rd_reg(7, v);  chk("R3", "x7 xor", v, 32'hFFFFFFF8);
        rd_reg(8, v);  chk("R3", "x8 slt signed", v, 32'd1);
        rd_reg(14, v); chk("R3", "x14 slt false", v, 32'd0);
        rd_reg(15, v); chk("R3", "x15 addi -2048", v, 32'hFFFFF800);
        rd_reg(9, v);  chk("R6", "x9 lw", v, pre[1]);
        rd_reg(10, v); chk("R5", "x10 load-use", v, pre[1] + 32'd5);
        rd_reg(0, v);  chk("R2", "x0 after write", v, 32'd0);
        rd_reg(11, v); chk("R7", "x11 squashed", v, 32'd0);
        rd_reg(12, v); chk("R7", "x12 squashed", v, 32'd0);
        rd_reg(13, v); chk("R8", "x13 fall-through", v, 32'd1);
        rd_reg(16, v); chk("R9", "x16 wb bypass", v, 32'd2);
        rd_reg(17, v); chk("R10", "x17 unsupported", v, 32'd0);
        rd_mem(2, v);  chk("R6", "word 2 store fwd", v, pre[1] + 32'd5);
        rd_mem(3, v);  chk("R6", "word 3 store", v, 32'hFFFFF800);

        // full state against the reference model (random section)
        for (int i = 0; i < 32; i++) begin
            rd_reg(i, v);
            chk("R3", $sformatf("x%0d vs model", i), v, ref_reg[i]);
        end
        for (int i = 0; i < 16; i++) begin
            rd_mem(i, v);
            chk("R6", $sformatf("word %0d vs model", i), v, ref_mem[i]);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule